// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Line Break

This block turns parallel words into asynchronous serial frames on a single output line. Software writes a word into a holding slot; whenever the output shifter is idle, or is just finishing its stop bit, the waiting word moves into the shifter and the slot is free again. Because of that hand-over, the next word can be queued while the current one is still going out, and consecutive frames leave with no idle time between them.

Two status outputs tell software when it may act. The slot-free flag, together with a one-cycle interrupt pulse when the slot drains, suits full-duplex streaming. The line-quiet flag rises only once every queued bit has left the pin, which is the moment to turn a half-duplex link around.

A small control register is written with set/clear semantics. The top bit of the write selects set or clear, and every lower bit written as one is changed. One of these bits forces the line low to send a break. The bit period is one more than a divisor input, which is shared with the matching receiver.

Top module: `uart_tx_buffered`

## Requirements
- R1: While reset is held and right after it, txOut is 1, bufEmpty is 1, shiftEmpty is 1, bufEmptyIrq is 0 and ctrlBits is all zeros.
- R2: A frame is one low start bit, then word bits 0 to DATA_W-1 least significant first, then word bit DATA_W as the stop bit. Every bit lasts baudDiv+1 clock cycles. When no frame is being sent, the line is high.
- R3: A data write clears bufEmpty in the cycle after the write. If the shifter is idle, the word moves into the shifter one cycle later: bufEmpty returns to 1 and txOut shows the start bit in that same cycle.
- R4: bufEmptyIrq is high for exactly one cycle, namely the cycle in which bufEmpty goes from 0 to 1.
- R5: A word that is waiting when the current frame's stop bit ends starts its own start bit in the very next cycle, with no idle cycle between the two frames.
- R6: shiftEmpty is 0 while any word is held or being shifted. It rises exactly FRAME_W*(baudDiv+1) cycles after the last word entered the shifter.
- R7: A data write while the holding slot is full replaces the waiting word. Only the newest word is sent.
- R8: A control write with bit CTRL_W-1 set to 1 sets every ctrlBits bit written as 1 and leaves all other bits unchanged.
- R9: A control write with bit CTRL_W-1 set to 0 clears every ctrlBits bit written as 1 and leaves all other bits unchanged.
- R10: While ctrlBits[BRK_BIT] (default bit 11) is 1, txOut is 0, starting the cycle after the write that sets it. Clearing the bit returns the line to its normal value.
- R11: A break does not stall or reset the bit timing. A frame that is overlapped by a break still ends at the cycle given in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudDiv | input | DIV_W | Bit period minus one, in clock cycles |
| dataWrEn | input | 1 | Write strobe for the holding slot |
| dataWrWord | input | DATA_W+1 | Data bits, with the stop bit at bit DATA_W |
| ctrlWrEn | input | 1 | Write strobe for the control register |
| ctrlWrWord | input | CTRL_W | Set/clear select in the top bit, bit mask below it |
| txOut | output | 1 | Serial line |
| bufEmpty | output | 1 | Holding slot free |
| shiftEmpty | output | 1 | Nothing held or shifting; line idle |
| bufEmptyIrq | output | 1 | One-cycle pulse when the slot becomes free |
| ctrlBits | output | CTRL_W-1 | Current control register contents |

## Verification
The bench builds the block with DATA_W=8, DIV_W=8 and the break control at bit 11 of a 16-bit control word. Directed sections use a divisor of 2, so each frame is 30 cycles long. This keeps the exact cycles of the slot hand-over, the gapless second frame, the overwrite of a waiting word and a break in mid-frame inside short windows. Random sections switch the divisor between 0 and 4. Divisor 0, where every bit lasts a single cycle, is the tightest case for the frame decoder and for back-to-back loading.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // move the holding word into the shifter
    logic bitTick;  // advance the shifter by one bit
  } txStrobeT;
endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int FRAME_W = 10,
  parameter int DIV_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             dataWrEn,
  output txStrobeT         strobe,
  output logic             bufEmpty,
  output logic             shiftEmpty,
  output logic             bufEmptyIrq
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic             busy;
  logic             holdFull;
  logic [DIV_W-1:0] baudCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             tickNow;
  logic             lastNow;
  logic             loadNow;

  always_comb begin
    tickNow = busy && (baudCnt >= baudDiv);
    lastNow = tickNow && (bitCnt == LAST_BIT);
    // a waiting word enters as soon as the shifter is free or finishing
    loadNow = holdFull && (!busy || lastNow);
    strobe.load    = loadNow;
    strobe.bitTick = tickNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      holdFull    <= 1'b0;
      baudCnt     <= '0;
      bitCnt      <= '0;
      bufEmptyIrq <= 1'b0;
    end else begin
      if (loadNow)      busy <= 1'b1;
      else if (lastNow) busy <= 1'b0;

      if (loadNow || tickNow) baudCnt <= '0;
      else if (busy)          baudCnt <= baudCnt + 1'b1;

      if (loadNow)      bitCnt <= '0;
      else if (tickNow) bitCnt <= bitCnt + 1'b1;

      if (dataWrEn)     holdFull <= 1'b1;
      else if (loadNow) holdFull <= 1'b0;

      bufEmptyIrq <= loadNow && !dataWrEn;
    end
  end

  assign bufEmpty   = !holdFull;
  assign shiftEmpty = !busy && !holdFull;
endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CTRL_W  = 16,
  parameter int BRK_BIT = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobeT          strobe,
  input  logic              dataWrEn,
  input  logic [DATA_W:0]   dataWrWord,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrWord,
  output logic              txOut,
  output logic [CTRL_W-2:0] ctrlBits
);
  localparam int WORD_W  = DATA_W + 1;
  localparam int FRAME_W = WORD_W + 1;

  logic [WORD_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;
  logic [CTRL_W-2:0]  ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '1;
    end else begin
      if (dataWrEn) holdReg <= dataWrWord;
      if (strobe.load)
        shiftReg <= {holdReg, 1'b0};
      else if (strobe.bitTick)
        shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  // each control bit follows the set/clear selector when its mask bit is 1
  for (genvar b = 0; b < CTRL_W - 1; b++) begin : g_ctrl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ctrlReg[b] <= 1'b0;
      else if (ctrlWrEn && ctrlWrWord[b])
        ctrlReg[b] <= ctrlWrWord[CTRL_W-1];
    end
  end

  assign ctrlBits = ctrlReg;
  assign txOut    = shiftReg[0] && !ctrlReg[BRK_BIT];
endmodule

// File: rtl/uart_tx_buffered.sv
module uart_tx_buffered
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 16,
  parameter int CTRL_W  = 16,
  parameter int BRK_BIT = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              dataWrEn,
  input  logic [DATA_W:0]   dataWrWord,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrWord,
  output logic              txOut,
  output logic              bufEmpty,
  output logic              shiftEmpty,
  output logic              bufEmptyIrq,
  output logic [CTRL_W-2:0] ctrlBits
);
  localparam int FRAME_W = DATA_W + 2;

  txStrobeT strobe;

  uart_tx_ctrl #(.FRAME_W(FRAME_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .dataWrEn(dataWrEn),
    .strobe(strobe), .bufEmpty(bufEmpty), .shiftEmpty(shiftEmpty),
    .bufEmptyIrq(bufEmptyIrq)
  );

  uart_tx_dp #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .BRK_BIT(BRK_BIT)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataWrEn(dataWrEn),
    .dataWrWord(dataWrWord), .ctrlWrEn(ctrlWrEn), .ctrlWrWord(ctrlWrWord),
    .txOut(txOut), .ctrlBits(ctrlBits)
  );
endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker #(
  parameter int CTRL_W  = 16,
  parameter int BRK_BIT = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWrEn,
  input logic [CTRL_W-1:0] ctrlWrWord,
  input logic              txOut,
  input logic              bufEmpty,
  input logic              shiftEmpty,
  input logic              bufEmptyIrq,
  input logic [CTRL_W-2:0] ctrlBits
);
  // R4: the pulse marks only a fresh transition to empty
  a_r4_irq_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    bufEmptyIrq |-> $rose(bufEmpty));
  a_r4_rise_has_irq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEmpty) |-> bufEmptyIrq);
  // R6: a quiet line implies a free slot
  a_r6_quiet_implies_free: assert property (@(posedge clk) disable iff (!rstN)
    shiftEmpty |-> bufEmpty);
  // R2: idle line is high unless broken
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEmpty && !ctrlBits[BRK_BIT]) |-> txOut);
  // R10: break holds the line low
  a_r10_break_low: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBits[BRK_BIT] |-> !txOut);
  // R8: set writes
  a_r8_set_bits: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && ctrlWrWord[CTRL_W-1]) |=>
      ((ctrlBits & $past(ctrlWrWord[CTRL_W-2:0])) == $past(ctrlWrWord[CTRL_W-2:0])));
  // R9: clear writes
  a_r9_clear_bits: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !ctrlWrWord[CTRL_W-1]) |=>
      ((ctrlBits & $past(ctrlWrWord[CTRL_W-2:0])) == '0));
endmodule

bind uart_tx_buffered uart_tx_checker #(.CTRL_W(CTRL_W), .BRK_BIT(BRK_BIT)) uChk (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrWord(ctrlWrWord),
  .txOut(txOut), .bufEmpty(bufEmpty), .shiftEmpty(shiftEmpty),
  .bufEmptyIrq(bufEmptyIrq), .ctrlBits(ctrlBits)
);

// File: tb/tb_uart_tx_buffered.sv
module tb_uart_tx_buffered;
  localparam int DATA_W  = 8;
  localparam int DIV_W   = 8;
  localparam int CTRL_W  = 16;
  localparam int BRK_BIT = 11;
  localparam int WORD_W  = DATA_W + 1;
  localparam int FRAME_W = DATA_W + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DIV_W-1:0]  baudDiv = 8'd2;
  logic dataWrEn = 1'b0;
  logic [WORD_W-1:0] dataWrWord = '0;
  logic ctrlWrEn = 1'b0;
  logic [CTRL_W-1:0] ctrlWrWord = '0;
  logic txOut, bufEmpty, shiftEmpty, bufEmptyIrq;
  logic [CTRL_W-2:0] ctrlBits;

  int total = 0;
  int bad = 0;
  bit monOn = 1'b1;
  logic [WORD_W-1:0] expQ[$];

  always #2.5 clk = ~clk;

  uart_tx_buffered #(.DATA_W(DATA_W), .DIV_W(DIV_W), .CTRL_W(CTRL_W), .BRK_BIT(BRK_BIT)) dut (
    .clk(clk), .rstN(rstN), .baudDiv(baudDiv), .dataWrEn(dataWrEn),
    .dataWrWord(dataWrWord), .ctrlWrEn(ctrlWrEn), .ctrlWrWord(ctrlWrWord),
    .txOut(txOut), .bufEmpty(bufEmpty), .shiftEmpty(shiftEmpty),
    .bufEmptyIrq(bufEmptyIrq), .ctrlBits(ctrlBits)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [WORD_W-1:0] mkWord(input logic [DATA_W-1:0] d);
    return {1'b1, d};
  endfunction

  function automatic int frameLen(input int div);
    return FRAME_W * (div + 1);
  endfunction

  // drive at a falling edge, return one falling edge later
  task automatic writeWord(input logic [WORD_W-1:0] w);
    if (monOn) begin
      if (bufEmpty || expQ.size() == 0) expQ.push_back(w);
      else expQ[expQ.size()-1] = w;   // overwrite of the waiting word
    end
    dataWrEn = 1'b1; dataWrWord = w;
    @(negedge clk);
    dataWrEn = 1'b0;
  endtask

  task automatic ctrlWrite(input logic [CTRL_W-1:0] w);
    ctrlWrEn = 1'b1; ctrlWrWord = w;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    while ((!shiftEmpty || expQ.size() != 0) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    @(negedge clk);
  endtask

  // frame decoder: samples every bit at its middle (R2)
  logic [WORD_W-1:0] monWord;
  bit prevTx = 1'b1;
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && monOn && prevTx && !txOut) begin
        int div;
        bit startLow;
        div = int'(baudDiv);
        repeat (div / 2) @(negedge clk);
        startLow = !txOut;
        for (int k = 0; k < WORD_W; k++) begin
          repeat (div + 1) @(negedge clk);
          monWord[k] = txOut;
        end
        chk(startLow, "R2 start bit", 0, 0);
        if (expQ.size() == 0) begin
          chk(1'b0, "R2 R7 unexpected frame", int'(monWord), 0);
        end else begin
          logic [WORD_W-1:0] e;
          e = expQ.pop_front();
          chk(monWord == e, "R2 R7 frame contents", int'(monWord), int'(e));
        end
        prevTx = 1'b1;
      end else begin
        prevTx = txOut;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txOut == 1'b1 && bufEmpty && shiftEmpty && !bufEmptyIrq && ctrlBits == '0,
        "R1 reset state", {txOut, bufEmpty, shiftEmpty, bufEmptyIrq}, 4'b1110);
    rstN = 1'b1;
    @(negedge clk);
    chk(txOut && bufEmpty && shiftEmpty && !bufEmptyIrq && ctrlBits == '0,
        "R1 after release", {txOut, bufEmpty, shiftEmpty, bufEmptyIrq}, 4'b1110);

    // single word, divisor 2
    baudDiv = 8'd2;
    writeWord(mkWord(8'hA5));
    chk(!bufEmpty, "R3 slot taken", bufEmpty, 0);
    @(negedge clk);  // index 0 of the frame
    chk(bufEmpty, "R3 slot freed", bufEmpty, 1);
    chk(bufEmptyIrq, "R4 pulse", bufEmptyIrq, 1);
    chk(!txOut, "R3 start bit", txOut, 0);
    @(negedge clk);
    chk(!bufEmptyIrq, "R4 pulse width", bufEmptyIrq, 0);
    repeat (frameLen(2) - 2) @(negedge clk);
    chk(!shiftEmpty, "R6 busy before end", shiftEmpty, 0);
    @(negedge clk);
    chk(shiftEmpty && txOut, "R6 quiet at end", {shiftEmpty, txOut}, 2'b11);
    waitIdle();

    // back-to-back frames and overwrite of the waiting word
    writeWord(mkWord(8'h3C));
    @(negedge clk);                       // index 0
    writeWord(mkWord(8'h11));             // index 1 on return
    chk(!bufEmpty && !shiftEmpty, "R6 held word", {bufEmpty, shiftEmpty}, 0);
    writeWord(mkWord(8'hE7));             // index 2, replaces 0x11 (R7)
    chk(!bufEmpty, "R7 still full", bufEmpty, 0);
    repeat (frameLen(2) - 3) @(negedge clk);
    chk(!bufEmptyIrq && !shiftEmpty && txOut, "R5 stop bit", {bufEmptyIrq, shiftEmpty, txOut}, 1);
    @(negedge clk);
    chk(!txOut && bufEmptyIrq && bufEmpty, "R5 gapless start", {txOut, bufEmptyIrq, bufEmpty}, 3'b011);
    repeat (frameLen(2) - 1) @(negedge clk);
    chk(!shiftEmpty, "R6 second frame busy", shiftEmpty, 0);
    @(negedge clk);
    chk(shiftEmpty, "R6 second frame done", shiftEmpty, 1);
    waitIdle();

    // control register set/clear and break on an idle line
    monOn = 1'b0;
    ctrlWrite(16'h8800);
    chk(!txOut, "R10 break low", txOut, 0);
    chk(ctrlBits == 15'h0800, "R8 set break", int'(ctrlBits), 'h0800);
    ctrlWrite(16'h8005);
    chk(ctrlBits == 15'h0805, "R8 set keeps others", int'(ctrlBits), 'h0805);
    ctrlWrite(16'h0001);
    chk(ctrlBits == 15'h0804, "R9 clear one bit", int'(ctrlBits), 'h0804);
    chk(!txOut, "R10 break still held", txOut, 0);
    ctrlWrite(16'h0804);
    chk(ctrlBits == '0, "R9 clear rest", int'(ctrlBits), 0);
    chk(txOut, "R10 released", txOut, 1);

    // break across a frame
    writeWord(mkWord(8'h00));
    repeat (4) @(negedge clk);            // index 3
    ctrlWrite(16'h8800);                  // index 4
    chk(!txOut, "R10 break mid frame", txOut, 0);
    repeat (10) @(negedge clk);           // index 14
    chk(!txOut && !shiftEmpty, "R11 break holds", {txOut, shiftEmpty}, 0);
    ctrlWrite(16'h0800);                  // index 15
    repeat (14) @(negedge clk);           // index 29
    chk(!shiftEmpty, "R11 timing kept", shiftEmpty, 0);
    @(negedge clk);                       // index 30
    chk(shiftEmpty && txOut, "R11 frame end", {shiftEmpty, txOut}, 2'b11);
    repeat (3) @(negedge clk);
    monOn = 1'b1;

    // random streams over several divisors
    for (int batch = 0; batch < 5; batch++) begin
      baudDiv = (batch == 0) ? 8'd0 : DIV_W'($urandom_range(0, 4));
      @(negedge clk);
      for (int n = 0; n < 12; n++) begin
        int guard = 0;
        while (!bufEmpty && guard < 2000) begin @(negedge clk); guard++; end
        repeat ($urandom_range(0, 3)) @(negedge clk);
        writeWord(mkWord(DATA_W'($urandom)));
      end
      waitIdle();
      chk(shiftEmpty && txOut && expQ.size() == 0, "R5 R6 stream drained",
          {shiftEmpty, txOut}, 2'b11);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule